// File: doc/BRIEF.md
# Multi-Mode Channel Equalizer with Delay

The block is a post-decimation equalizer for two sample lanes. The lanes carry I and Q or two independent real streams. Both lanes first go through a fixed coarse gain of 0, 3 or 6 dB. A 96-entry coefficient bank then filters them, and a mode input selects how the bank is split: one long real filter, two real filters, a half-complex arrangement, or a 2x2 complex filter. A fifth mode skips filtering and only delays the lanes. In every enabled mode, a delay of 0 to 127 clock cycles can be added at the output.

Software loads the coefficients one word per cycle through a write port. The mode, the tap count, the delay and the gain are static inputs. If the tap count is illegal for the selected mode, both outputs are held at zero and an error flag is raised. When the enable is low, the lanes pass through one register unchanged. The filter accepts one new sample per lane on every clock.

Top module: `chan_eq`

## Requirements
- R1: While rst_ni is low, both output lanes and tap_err_o are 0. Reset also clears every coefficient, the sample history and the delay line.
- R2: Coarse gain codes are 0 for 0 dB (x16384), 1 for 3 dB (x23142) and 2 for 6 dB (x32690). Code 3 acts as 0 dB. The result is (x*K)>>>14 with floor rounding, saturated to signed 16 bits, and applied to both lanes ahead of the filter and the delay path.
- R3: Mode 0 (single) gives lane0_o = sat((sum over k<N of c[k]*g0[n-k])>>>15), and lane1_o is 0. Here g0 is gained lane 0 and N is the tap count. A sample set up before clock edge t enters as tap 0 in the output after edge t+1+D, where D is the delay.
- R4: Modes 1 (dual) and 2 (half complex) filter lane 0 with taps 0..N/2-1 and lane 1 with taps 48..48+N/2-1. Each lane goes to its own output.
- R5: Mode 3 (full complex) gives lane0_o = sum over k<N/4 of c[k]*g0 + c[48+k]*g1, and lane1_o = sum over k<N/4 of c[24+k]*g0 + c[72+k]*g1. Both use the same scaling and saturation as R3.
- R6: Mode 4 (delay only) outputs the gained lanes with no filtering. The tap count is ignored and never raises the error flag.
- R7: The delay input D (0..127) adds exactly D clock cycles of latency in every enabled mode.
- R8: The tap count N must lie in 1..96. It must be even in modes 1 and 2, and a multiple of 4 in mode 3. Modes 5 to 7 are always illegal. An illegal setting gives tap_err_o = 1 and both output lanes 0.
- R9: With en_i low, each output lane equals its input lane one clock later, with no gain applied, and tap_err_o is 0.
- R10: When coef_we_i is high, a write to address 0..95 sets that coefficient (signed, 15 fractional bits). A write to any address of 96 or above is ignored.
- R11: Filter results above 32767 or below -32768 saturate to those limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Equalizer enable; 0 selects pass-through |
| mode_i | input | 3 | Bank split mode (0..4) |
| ntaps_i | input | 7 | Tap count N |
| delay_i | input | 7 | Extra output delay in cycles |
| gain_sel_i | input | 2 | Coarse gain code |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 7 | Coefficient index |
| coef_data_i | input | 16 | Coefficient value, signed |
| lane0_i | input | 16 | Input lane 0, signed |
| lane1_i | input | 16 | Input lane 1, signed |
| lane0_o | output | 16 | Output lane 0, signed |
| lane1_o | output | 16 | Output lane 1, signed |
| tap_err_o | output | 1 | Illegal tap count or mode |

## Verification
In full-complex mode the bench looks for cross terms that go to the wrong output. A design that swapped the 24-tap quarters would mix the I and Q paths. The bench also checks the half split at tap 48 in dual mode with N=96, where an off-by-one would leak lane 0 history into lane 1.

The delay is checked at 0, small values and the maximum of 127. A wrong tap select in the delay line would show a one-cycle skew. Tap counts that are odd, not a multiple of four, 0 or 97 are all tried, and a design that range-checked loosely would emit filtered data instead of zeros. A coefficient write to address 98 must leave coefficient 2 untouched, which catches address aliasing. Saturation is driven with full-scale inputs and coefficients at 6 dB, where a wrap instead of a clamp flips the output sign.

// File: rtl/chan_eq_pkg.sv
package chan_eq_pkg;

  typedef enum logic [2:0] {
    EQ_SINGLE    = 3'd0,
    EQ_DUAL      = 3'd1,
    EQ_HALF_CPLX = 3'd2,
    EQ_FULL_CPLX = 3'd3,
    EQ_DELAY     = 3'd4
  } eq_mode_e;

  localparam int unsigned GAIN_FRAC = 14;
  localparam logic signed [17:0] GAIN_K_0DB = 18'sd16384;
  localparam logic signed [17:0] GAIN_K_3DB = 18'sd23142;
  localparam logic signed [17:0] GAIN_K_6DB = 18'sd32690;

  function automatic logic taps_legal(logic [2:0] mode, int n, int ntap);
    logic in_range;
    in_range = (n >= 1) && (n <= ntap);
    case (mode)
      EQ_SINGLE:             return in_range;
      EQ_DUAL, EQ_HALF_CPLX: return in_range && (n % 2 == 0);
      EQ_FULL_CPLX:          return in_range && (n % 4 == 0);
      EQ_DELAY:              return 1'b1;
      default:               return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/eq_coarse_gain.sv
module eq_coarse_gain
  import chan_eq_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic [1:0]           sel_i,
  input  logic signed [DW-1:0] x_i,
  output logic signed [DW-1:0] y_o
);
  localparam int unsigned PW = DW + 18;
  localparam logic signed [PW-1:0] SMAX = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] SMIN = ~SMAX;

  logic signed [17:0]   k;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] sh;

  always_comb begin
    case (sel_i)
      2'd1:    k = GAIN_K_3DB;
      2'd2:    k = GAIN_K_6DB;
      default: k = GAIN_K_0DB;
    endcase
    prod = PW'(x_i) * PW'(k);
    sh   = prod >>> GAIN_FRAC;
    if (sh > SMAX)      y_o = SMAX[DW-1:0];
    else if (sh < SMIN) y_o = SMIN[DW-1:0];
    else                y_o = sh[DW-1:0];
    // a positive gain never flips the sign
    if (!x_i[DW-1]) assert_gain_sign_R2: assert (!y_o[DW-1]);
  end

endmodule

// File: rtl/eq_tap_bank.sv
module eq_tap_bank
  import chan_eq_pkg::*;
#(
  parameter int unsigned DW   = 16,
  parameter int unsigned CW   = 16,
  parameter int unsigned NTAP = 96,
  parameter int unsigned AW   = 40,
  parameter int unsigned AD   = 7,
  parameter int unsigned NW   = 7
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 coef_we_i,
  input  logic [AD-1:0]        coef_addr_i,
  input  logic signed [CW-1:0] coef_data_i,
  input  logic [2:0]           mode_i,
  input  logic [NW-1:0]        ntaps_i,
  input  logic signed [DW-1:0] g0_i,
  input  logic signed [DW-1:0] g1_i,
  output logic signed [DW-1:0] tap0_0_o,
  output logic signed [DW-1:0] tap0_1_o,
  output logic signed [AW-1:0] acc0_o,
  output logic signed [AW-1:0] acc1_o
);
  localparam int unsigned HALF = NTAP / 2;
  localparam int unsigned QTR  = NTAP / 4;

  typedef logic signed [AW-1:0] acc_t;

  logic signed [CW-1:0] coef_q [NTAP];
  logic signed [DW-1:0] h0_q   [NTAP];
  logic signed [DW-1:0] h1_q   [HALF];

  function automatic acc_t mul(logic signed [DW-1:0] x, logic signed [CW-1:0] c);
    return acc_t'(x) * acc_t'(c);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAP; k++) coef_q[k] <= '0;
    end else if (coef_we_i && (32'(coef_addr_i) < NTAP)) begin
      coef_q[coef_addr_i] <= coef_data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NTAP; k++) h0_q[k] <= '0;
      for (int k = 0; k < HALF; k++) h1_q[k] <= '0;
    end else begin
      h0_q[0] <= g0_i;
      h1_q[0] <= g1_i;
      for (int k = 1; k < NTAP; k++) h0_q[k] <= h0_q[k-1];
      for (int k = 1; k < HALF; k++) h1_q[k] <= h1_q[k-1];
    end
  end

  always_comb begin
    int n;
    n      = int'(ntaps_i);
    acc0_o = '0;
    acc1_o = '0;
    case (mode_i)
      EQ_SINGLE: begin
        for (int k = 0; k < NTAP; k++)
          if (k < n) acc0_o = acc0_o + mul(h0_q[k], coef_q[k]);
      end
      EQ_DUAL, EQ_HALF_CPLX: begin
        for (int k = 0; k < HALF; k++)
          if (k < n / 2) begin
            acc0_o = acc0_o + mul(h0_q[k], coef_q[k]);
            acc1_o = acc1_o + mul(h1_q[k], coef_q[HALF+k]);
          end
      end
      EQ_FULL_CPLX: begin
        // 2x2: quarter 0/2 feed output 0, quarter 1/3 feed output 1
        for (int k = 0; k < QTR; k++)
          if (k < n / 4) begin
            acc0_o = acc0_o + mul(h0_q[k], coef_q[k])
                            + mul(h1_q[k], coef_q[HALF+k]);
            acc1_o = acc1_o + mul(h0_q[k], coef_q[QTR+k])
                            + mul(h1_q[k], coef_q[HALF+QTR+k]);
          end
      end
      default: ;
    endcase
  end

  assign tap0_0_o = h0_q[0];
  assign tap0_1_o = h1_q[0];

endmodule

// File: rtl/eq_delay_line.sv
module eq_delay_line #(
  parameter int unsigned W    = 32,
  parameter int unsigned DMAX = 127,
  parameter int unsigned DLW  = 7
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [DLW-1:0] dly_i,
  input  logic [W-1:0]   d_i,
  output logic [W-1:0]   q_o
);
  logic [W-1:0] sr_q [DMAX];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DMAX; k++) sr_q[k] <= '0;
    end else begin
      sr_q[0] <= d_i;
      for (int k = 1; k < DMAX; k++) sr_q[k] <= sr_q[k-1];
    end
  end

  always_comb begin
    if (dly_i == '0)             q_o = d_i;
    else if (32'(dly_i) > DMAX)  q_o = sr_q[DMAX-1];
    else                         q_o = sr_q[DLW'(dly_i - 1'b1)];
  end

endmodule

// File: rtl/chan_eq.sv
module chan_eq
  import chan_eq_pkg::*;
#(
  parameter  int unsigned DW      = 16,
  parameter  int unsigned CW      = 16,
  parameter  int unsigned NTAP    = 96,
  parameter  int unsigned DLY_MAX = 127,
  localparam int unsigned AD      = $clog2(NTAP),
  localparam int unsigned NW      = $clog2(NTAP + 1),
  localparam int unsigned DLW     = $clog2(DLY_MAX + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [2:0]           mode_i,
  input  logic [NW-1:0]        ntaps_i,
  input  logic [DLW-1:0]       delay_i,
  input  logic [1:0]           gain_sel_i,
  input  logic                 coef_we_i,
  input  logic [AD-1:0]        coef_addr_i,
  input  logic signed [CW-1:0] coef_data_i,
  input  logic signed [DW-1:0] lane0_i,
  input  logic signed [DW-1:0] lane1_i,
  output logic signed [DW-1:0] lane0_o,
  output logic signed [DW-1:0] lane1_o,
  output logic                 tap_err_o
);
  localparam int unsigned AW = DW + CW + $clog2(NTAP) + 2;
  localparam logic signed [AW-1:0] SMAX = {{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [AW-1:0] SMIN = ~SMAX;

  logic signed [DW-1:0] lane_in [2];
  logic signed [DW-1:0] gained  [2];
  logic signed [DW-1:0] tap0    [2];
  logic signed [AW-1:0] acc     [2];
  logic signed [DW-1:0] filt    [2];
  logic signed [DW-1:0] pick    [2];
  logic [2*DW-1:0]      dly_out;
  logic                 legal;
  logic                 live_q;

  assign lane_in[0] = lane0_i;
  assign lane_in[1] = lane1_i;

  for (genvar l = 0; l < 2; l++) begin : g_gain
    eq_coarse_gain #(.DW(DW)) gain_i (
      .sel_i (gain_sel_i),
      .x_i   (lane_in[l]),
      .y_o   (gained[l])
    );
  end

  eq_tap_bank #(
    .DW(DW), .CW(CW), .NTAP(NTAP), .AW(AW), .AD(AD), .NW(NW)
  ) bank_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .coef_we_i   (coef_we_i),
    .coef_addr_i (coef_addr_i),
    .coef_data_i (coef_data_i),
    .mode_i      (mode_i),
    .ntaps_i     (ntaps_i),
    .g0_i        (gained[0]),
    .g1_i        (gained[1]),
    .tap0_0_o    (tap0[0]),
    .tap0_1_o    (tap0[1]),
    .acc0_o      (acc[0]),
    .acc1_o      (acc[1])
  );

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      logic signed [AW-1:0] sh;
      sh = acc[l] >>> (CW - 1);
      if (sh > SMAX)      filt[l] = SMAX[DW-1:0];
      else if (sh < SMIN) filt[l] = SMIN[DW-1:0];
      else                filt[l] = sh[DW-1:0];
      pick[l] = (mode_i == EQ_DELAY) ? tap0[l] : filt[l];
    end
  end

  eq_delay_line #(.W(2*DW), .DMAX(DLY_MAX), .DLW(DLW)) dly_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .dly_i  (delay_i),
    .d_i    ({pick[1], pick[0]}),
    .q_o    (dly_out)
  );

  assign legal = taps_legal(mode_i, int'(ntaps_i), int'(NTAP));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane0_o   <= '0;
      lane1_o   <= '0;
      tap_err_o <= 1'b0;
      live_q    <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (!en_i) begin
        lane0_o   <= lane0_i;
        lane1_o   <= lane1_i;
        tap_err_o <= 1'b0;
      end else if (!legal) begin
        lane0_o   <= '0;
        lane1_o   <= '0;
        tap_err_o <= 1'b1;
      end else begin
        lane0_o   <= dly_out[DW-1:0];
        lane1_o   <= dly_out[2*DW-1:DW];
        tap_err_o <= 1'b0;
      end
    end
  end

  assert_bypass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(live_q && !en_i) |->
      (lane0_o == $past(lane0_i)) && (lane1_o == $past(lane1_i)) && !tap_err_o);

  assert_single_lane1_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(live_q && en_i && mode_i == 3'd0) |-> lane1_o == '0);

  assert_delay_mode_no_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(live_q && en_i && mode_i == 3'd4) |-> !tap_err_o);

  assert_odd_split_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(live_q && en_i && (mode_i == 3'd1 || mode_i == 3'd2) && ntaps_i[0]) |->
      tap_err_o && lane0_o == '0 && lane1_o == '0);

  assert_bad_mode_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(live_q && en_i && mode_i > 3'd4) |-> tap_err_o);

endmodule

// File: tb/chan_eq_tb_top.sv
module chan_eq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT   = 96;
  localparam int MAXL = 256;
  localparam int WDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              en_i = 1'b0;
  logic [2:0]        mode_i = '0;
  logic [6:0]        ntaps_i = '0;
  logic [6:0]        delay_i = '0;
  logic [1:0]        gain_sel_i = '0;
  logic              coef_we_i = 1'b0;
  logic [6:0]        coef_addr_i = '0;
  logic signed [15:0] coef_data_i = '0;
  logic signed [15:0] lane0_i = '0;
  logic signed [15:0] lane1_i = '0;
  logic signed [15:0] lane0_o;
  logic signed [15:0] lane1_o;
  logic              tap_err_o;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit [31:0] seed = 32'h1234_5678;

  int coef [NT];
  int raw0 [MAXL];
  int raw1 [MAXL];
  int g0   [MAXL];
  int g1   [MAXL];

  bit m_en;
  int m_mode, m_n, m_d, m_sel;

  chan_eq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i), .mode_i(mode_i),
    .ntaps_i(ntaps_i), .delay_i(delay_i), .gain_sel_i(gain_sel_i),
    .coef_we_i(coef_we_i), .coef_addr_i(coef_addr_i), .coef_data_i(coef_data_i),
    .lane0_i(lane0_i), .lane1_i(lane1_i),
    .lane0_o(lane0_o), .lane1_o(lane1_o), .tap_err_o(tap_err_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WDOG) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: got %0d cycles, expected under %0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  function automatic int next_rand(int amp);
    seed ^= seed << 13;
    seed ^= seed >> 17;
    seed ^= seed << 5;
    return int'(seed % 32'(2*amp + 1)) - amp;
  endfunction

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  function automatic int gain_ref(int x, int sel);
    longint k;
    k = (sel == 1) ? 23142 : (sel == 2) ? 32690 : 16384;
    return sat16((longint'(x) * k) >>> 14);
  endfunction

  function automatic bit legal_ref(int mode, int n);
    bit r;
    r = (n >= 1) && (n <= NT);
    case (mode)
      0: return r;
      1, 2: return r && (n % 2 == 0);
      3: return r && (n % 4 == 0);
      4: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic longint gv(int lane, int i);
    if (i < 0) return 0;
    return (lane == 0) ? longint'(g0[i]) : longint'(g1[i]);
  endfunction

  function automatic int filt_ref(int lane, int idx);
    longint s = 0;
    case (m_mode)
      0: if (lane == 0) for (int k = 0; k < m_n; k++) s += coef[k] * gv(0, idx-k);
      1, 2: for (int k = 0; k < m_n/2; k++)
              s += (lane == 0) ? coef[k] * gv(0, idx-k) : coef[48+k] * gv(1, idx-k);
      3: for (int k = 0; k < m_n/4; k++)
           s += (lane == 0) ? coef[k] * gv(0, idx-k) + coef[48+k] * gv(1, idx-k)
                            : coef[24+k] * gv(0, idx-k) + coef[72+k] * gv(1, idx-k);
      default: ;
    endcase
    return sat16(s >>> 15);
  endfunction

  task automatic compare(string tag, int t);
    int e0, e1;
    bit ee;
    ee = 1'b0;
    if (!m_en) begin
      e0 = (t >= 1) ? raw0[t-1] : 0;
      e1 = (t >= 1) ? raw1[t-1] : 0;
    end else if (!legal_ref(m_mode, m_n)) begin
      e0 = 0; e1 = 0; ee = 1'b1;
    end else if (m_mode == 4) begin
      e0 = int'(gv(0, t-2-m_d));
      e1 = int'(gv(1, t-2-m_d));
    end else begin
      e0 = filt_ref(0, t-2-m_d);
      e1 = filt_ref(1, t-2-m_d);
    end
    n_cmp++;
    if (int'(lane0_o) != e0 || int'(lane1_o) != e1 || tap_err_o != ee) begin
      n_bad++;
      $display("FAIL %s t=%0d: got %0d/%0d err=%0b, expected %0d/%0d err=%0b",
               tag, t, lane0_o, lane1_o, tap_err_o, e0, e1, ee);
    end
  endtask

  task automatic run_case(string tag, bit en, int mode, int n, int d, int sel,
                          int amp, bit cmax, bit alias_wr, int len);
    m_en = en; m_mode = mode; m_n = n; m_d = d; m_sel = sel;
    @(negedge clk);
    rst_ni = 1'b0;
    en_i = en; mode_i = 3'(mode); ntaps_i = 7'(n); delay_i = 7'(d);
    gain_sel_i = 2'(sel); lane0_i = '0; lane1_i = '0; coef_we_i = 1'b0;
    repeat (2) @(negedge clk);
    // R1: reset state
    n_cmp++;
    if (lane0_o != 0 || lane1_o != 0 || tap_err_o != 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got %0d/%0d err=%0b, expected 0/0 err=0",
               lane0_o, lane1_o, tap_err_o);
    end
    rst_ni = 1'b1;
    for (int a = 0; a < NT; a++) begin
      coef[a] = cmax ? 32767 : next_rand(20000);
      @(negedge clk);
      coef_we_i = 1'b1; coef_addr_i = 7'(a); coef_data_i = 16'(coef[a]);
    end
    if (alias_wr) begin
      // R10: address 98 lies outside the bank and must not touch coefficient 2
      @(negedge clk);
      coef_addr_i = 7'd98; coef_data_i = 16'sd30001;
    end
    @(negedge clk);
    coef_we_i = 1'b0;
    for (int t = 0; t < len; t++) begin
      raw0[t] = next_rand(amp);
      raw1[t] = next_rand(amp);
      g0[t] = gain_ref(raw0[t], sel);
      g1[t] = gain_ref(raw1[t], sel);
    end
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      compare(tag, t);
      lane0_i = 16'(raw0[t]);
      lane1_i = 16'(raw1[t]);
    end
    lane0_i = '0; lane1_i = '0;
  endtask

  task automatic t_single();     run_case("R3",     1, 0, 96, 0,   0, 8000, 0, 0, 160); endtask
  task automatic t_single_dly(); run_case("R2/R7",  1, 0, 5,  3,   1, 8000, 0, 0, 60);  endtask
  task automatic t_gain3();      run_case("R2",     1, 0, 4,  0,   3, 9000, 0, 0, 40);  endtask
  task automatic t_dual();       run_case("R4 R2",  1, 1, 10, 0,   2, 8000, 0, 0, 60);  endtask
  task automatic t_half();       run_case("R4",     1, 2, 96, 5,   0, 8000, 0, 0, 120); endtask
  task automatic t_full8();      run_case("R5",     1, 3, 8,  0,   0, 8000, 0, 0, 60);  endtask
  task automatic t_full96();     run_case("R5 R7",  1, 3, 96, 2,   0, 6000, 0, 0, 120); endtask
  task automatic t_dly_max();    run_case("R6 R7",  1, 4, 0,  127, 1, 9000, 0, 0, 200); endtask
  task automatic t_dly_zero();   run_case("R6",     1, 4, 33, 0,   0, 9000, 0, 0, 30);  endtask
  task automatic t_illegal();
    run_case("R8 odd dual",   1, 1, 7,  0, 0, 8000, 0, 0, 20);
    run_case("R8 full non4",  1, 3, 6,  0, 0, 8000, 0, 0, 20);
    run_case("R8 zero taps",  1, 0, 0,  0, 0, 8000, 0, 0, 20);
    run_case("R8 97 taps",    1, 0, 97, 0, 0, 8000, 0, 0, 20);
    run_case("R8 bad mode",   1, 6, 8,  0, 0, 8000, 0, 0, 20);
  endtask
  task automatic t_bypass();     run_case("R9",     0, 1, 7,  9,   2, 20000, 0, 0, 40); endtask
  task automatic t_saturate();   run_case("R11 R2", 1, 1, 96, 0,   2, 32767, 1, 0, 80); endtask
  task automatic t_alias();      run_case("R10",    1, 0, 8,  0,   0, 8000, 0, 1, 40);  endtask

  initial begin
    t_single();
    t_single_dly();
    t_gain3();
    t_dual();
    t_half();
    t_full8();
    t_full96();
    t_dly_max();
    t_dly_zero();
    t_illegal();
    t_bypass();
    t_saturate();
    t_alias();
    summary();
    $finish;
  end

endmodule